// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register Window

This block is the programming front end of an I/O interrupt controller with 24 request pins. A bus agent first loads a select register and then reads or writes a single 32-bit data window. The select value picks one of three small identification registers or one 32-bit half of a 64-bit redirection entry. There is one entry per pin. The block stores the whole redirection table and presents every entry's fields as flat output vectors, so the delivery logic can use them directly.

Writes through the window have side effects that the servicing logic relies on. Rewriting the low half of an entry drops that entry's remote-pending flag. A write that flips an entry's mask produces a one-cycle mask-change event. A write that leaves an entry level-triggered while its pin is requesting produces a one-cycle re-evaluation event. Remote-pending is set from outside, by the servicing logic, through a per-pin strobe. Interrupt delivery itself is not part of this block.

Top module: `irq_regwin`

## Requirements
- R1: Only the low 8 address bits are decoded. Offset 0x00 is the select register, which reads back its full 32-bit value. Offset 0x10 is the data window. A read at any other offset returns 0, and a write at any other offset changes nothing.
- R2: Select value 1 is the version register. It reads as (PINS-1) in bits 23:16 and VER_CODE in bits 7:0, with all other bits 0 (0x00170011 with the defaults). Writes to it are ignored.
- R3: Select value 0 is the identification register. A write stores data bits 27:24 as a 4-bit ID, and a read returns the ID in bits 27:24 with all other bits 0. Select value 2 reads back the same field, and writes to it are ignored.
- R4: For a select value S of 0x10 or more, the entry index is (S-0x10)>>1. When S bit 0 is 1 the window reaches entry bits 63:32, and when it is 0 the window reaches bits 31:0.
- R5: A window write whose entry index is PINS or more leaves all entries unchanged and raises no event. A read at such an index returns 0.
- R6: A low-half write stores the data and then forces remote-pending (bit 14) to 0. A high-half write keeps bit 14 unchanged.
- R7: When a write changes an entry's mask (bit 16), mchg_valid is high for exactly the cycle after the write, with mchg_pin holding the index and mchg_mask holding the new mask.
- R8: After any entry write, if the entry's trigger mode (bit 15, 1 = level) is level and that pin's registered request bit is 1, reeval_valid is high for the next cycle, with reeval_pin holding the index.
- R9: Reset sets the mask bit of every entry and clears all other entry bits, the select register, the ID and all request bits.
- R10: A write whose acc_size is neither 4 nor 8 bytes is ignored at every offset. Only data bits 31:0 are used.
- R11: The entry fields appear on the outputs as follows: vector is bits 7:0, delivery mode bits 10:8, destination mode bit 11, polarity bit 13, remote-pending bit 14, trigger bit 15, mask bit 16 and destination bits 63:56. Bit 12 and the reserved bits are stored as written.
- R12: A pulse on rp_set[i] sets entry i's remote-pending bit in the next cycle. If a low-half write to the same entry happens in the same cycle, the clear from R6 wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Bus access in this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Low address byte |
| acc_size | input | 4 | Access size in bytes |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read result, registered, valid the cycle after a read |
| irq_req | input | PINS | Pin request levels, registered internally |
| rp_set | input | PINS | Per-pin strobe that sets remote-pending |
| ent_vector | output | 8*PINS | Vector of each entry |
| ent_dlv | output | 3*PINS | Delivery mode of each entry |
| ent_dstmode | output | PINS | Destination mode of each entry |
| ent_pol | output | PINS | Polarity of each entry |
| ent_rpend | output | PINS | Remote-pending of each entry |
| ent_trig | output | PINS | Trigger mode of each entry, 1 = level |
| ent_mask | output | PINS | Mask of each entry |
| ent_dest | output | 8*PINS | Destination of each entry |
| mchg_valid | output | 1 | Mask-change event |
| mchg_pin | output | IDX_W | Pin of the mask-change event |
| mchg_mask | output | 1 | New mask value |
| reeval_valid | output | 1 | Re-evaluation request |
| reeval_pin | output | IDX_W | Pin to re-evaluate |

## Verification
Two functions can act on the same remote-pending bit in one cycle: the software low-half write that clears it, and the servicing strobe that sets it. The stimulus raises rp_set sparsely and at random while entry writes run, and it also forces the two to meet on one pin in a directed step. The result is judged by reading the entry back and by comparing the exported remote-pending vector with a bench model. A single write can also raise both the mask-change event and the re-evaluation event together, and both events are compared in that same cycle.

// File: rtl/irq_regwin_pkg.sv
package irq_regwin_pkg;

    // bus offsets (low address byte)
    localparam logic [7:0] OFS_SELECT = 8'h00;
    localparam logic [7:0] OFS_WINDOW = 8'h10;

    // select codes
    localparam logic [31:0] SEL_IDENT      = 32'd0;
    localparam logic [31:0] SEL_VERSION    = 32'd1;
    localparam logic [31:0] SEL_ARBIT      = 32'd2;
    localparam logic [31:0] SEL_TABLE_BASE = 32'h10;

    // entry bit positions
    localparam int B_RPEND   = 14;
    localparam int B_TRIG    = 15;
    localparam int B_MASK    = 16;

    typedef logic [63:0] rte_t;

    localparam rte_t RTE_RESET = 64'h0000_0000_0001_0000;

    typedef struct packed {
        logic [7:0] dest;
        logic       mask;
        logic       trig;
        logic       rpend;
        logic       pol;
        logic       dstmode;
        logic [2:0] dlv;
        logic [7:0] vector;
    } rte_fields_t;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_SELECT,
        TGT_WINDOW
    } tgt_e;

    function automatic rte_fields_t rte_unpack(rte_t e);
        rte_fields_t f;
        f.vector  = e[7:0];
        f.dlv     = e[10:8];
        f.dstmode = e[11];
        f.pol     = e[13];
        f.rpend   = e[B_RPEND];
        f.trig    = e[B_TRIG];
        f.mask    = e[B_MASK];
        f.dest    = e[63:56];
        return f;
    endfunction

    function automatic logic size_ok(logic [3:0] s);
        return (s == 4'd4) || (s == 4'd8);
    endfunction

    function automatic tgt_e decode_tgt(logic [7:0] a);
        if (a == OFS_SELECT) return TGT_SELECT;
        if (a == OFS_WINDOW) return TGT_WINDOW;
        return TGT_NONE;
    endfunction

    function automatic logic [31:0] rte_half(rte_t e, logic hi);
        return hi ? e[63:32] : e[31:0];
    endfunction

    // apply one 32-bit window write to an entry
    function automatic rte_t rte_merge(rte_t old, logic hi, logic [31:0] d);
        rte_t r;
        if (hi) begin
            r = {d, old[31:0]};
        end else begin
            r = {old[63:32], d};
            r[B_RPEND] = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_regwin_decode.sv
module irq_regwin_decode
    import irq_regwin_pkg::*;
#(
    parameter int         PINS     = 24,
    parameter logic [7:0] VER_CODE = 8'h11,
    parameter int         IDX_W    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [7:0]       acc_addr,
    input  logic [3:0]       acc_size,
    input  logic [31:0]      acc_wdata,
    input  rte_t             sel_entry,
    output logic [31:0]      sel_q,
    output logic [IDX_W-1:0] sel_idx,
    output logic             tbl_wr,
    output logic             tbl_hi,
    output logic [31:0]      tbl_wdata,
    output logic [31:0]      rd_data
);

    localparam logic [7:0] PIN_MAX = 8'(PINS - 1);

    logic [3:0]  id_q;
    tgt_e        tgt;
    logic        wr_ok;
    logic        in_tbl;
    logic [31:0] idx_full;
    logic [31:0] win_rd;
    logic [31:0] rd_next;

    always_comb begin
        tgt       = decode_tgt(acc_addr);
        wr_ok     = acc_valid && acc_write && size_ok(acc_size);
        idx_full  = (sel_q - SEL_TABLE_BASE) >> 1;
        in_tbl    = (sel_q >= SEL_TABLE_BASE) && (idx_full < 32'(PINS));
        sel_idx   = idx_full[IDX_W-1:0];
        tbl_hi    = sel_q[0];
        tbl_wdata = acc_wdata;
        tbl_wr    = wr_ok && (tgt == TGT_WINDOW) && in_tbl;
    end

    always_comb begin
        if (sel_q == SEL_IDENT || sel_q == SEL_ARBIT)
            win_rd = {4'b0, id_q, 24'b0};
        else if (sel_q == SEL_VERSION)
            win_rd = {8'h00, PIN_MAX, 8'h00, VER_CODE};
        else if (in_tbl)
            win_rd = rte_half(sel_entry, sel_q[0]);
        else
            win_rd = 32'h0;

        case (tgt)
            TGT_SELECT: rd_next = sel_q;
            TGT_WINDOW: rd_next = win_rd;
            default:    rd_next = 32'h0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= 32'h0;
            id_q    <= 4'h0;
            rd_data <= 32'h0;
        end else begin
            if (wr_ok && tgt == TGT_SELECT)
                sel_q <= acc_wdata;
            if (wr_ok && tgt == TGT_WINDOW && sel_q == SEL_IDENT)
                id_q <= acc_wdata[27:24];
            if (acc_valid && !acc_write)
                rd_data <= rd_next;
        end
    end

endmodule

// File: rtl/irq_regwin_table.sv
module irq_regwin_table
    import irq_regwin_pkg::*;
#(
    parameter int PINS  = 24,
    parameter int IDX_W = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 wr_hi,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [31:0]          wr_data,
    input  logic [PINS-1:0]      rp_set,
    output rte_t                 sel_entry,
    output logic [PINS-1:0][63:0] ent_q
);

    for (genvar g = 0; g < PINS; g++) begin : g_ent
        rte_t r_q;
        rte_t r_nx;

        always_comb begin
            r_nx = r_q;
            if (rp_set[g])
                r_nx[B_RPEND] = 1'b1;
            if (wr_en && wr_idx == IDX_W'(g))
                r_nx = rte_merge(r_nx, wr_hi, wr_data);
        end

        always_ff @(posedge clk) begin
            if (rst) r_q <= RTE_RESET;
            else     r_q <= r_nx;
        end

        assign ent_q[g] = r_q;
    end

    always_comb begin
        if (32'(wr_idx) < 32'(PINS)) sel_entry = ent_q[wr_idx];
        else                         sel_entry = '0;
    end

endmodule

// File: rtl/irq_regwin_events.sv
module irq_regwin_events
    import irq_regwin_pkg::*;
#(
    parameter int PINS  = 24,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_hi,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  rte_t             cur_entry,
    input  logic [PINS-1:0]  irq_req,
    output logic             mchg_valid,
    output logic [IDX_W-1:0] mchg_pin,
    output logic             mchg_mask,
    output logic             reeval_valid,
    output logic [IDX_W-1:0] reeval_pin
);

    logic [PINS-1:0] req_q;
    rte_t            new_entry;
    logic            mask_flip;
    logic            req_hit;

    always_comb begin
        new_entry = rte_merge(cur_entry, wr_hi, wr_data);
        mask_flip = new_entry[B_MASK] != cur_entry[B_MASK];
        req_hit   = (32'(wr_idx) < 32'(PINS)) ? req_q[wr_idx] : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q        <= '0;
            mchg_valid   <= 1'b0;
            mchg_pin     <= '0;
            mchg_mask    <= 1'b0;
            reeval_valid <= 1'b0;
            reeval_pin   <= '0;
        end else begin
            req_q        <= irq_req;
            mchg_valid   <= wr_en && mask_flip;
            reeval_valid <= wr_en && new_entry[B_TRIG] && req_hit;
            if (wr_en) begin
                mchg_pin   <= wr_idx;
                mchg_mask  <= new_entry[B_MASK];
                reeval_pin <= wr_idx;
            end
        end
    end

endmodule

// File: rtl/irq_regwin.sv
module irq_regwin
    import irq_regwin_pkg::*;
#(
    parameter int         PINS     = 24,
    parameter logic [7:0] VER_CODE = 8'h11,
    parameter int         IDX_W    = $clog2(PINS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [7:0]        acc_addr,
    input  logic [3:0]        acc_size,
    input  logic [31:0]       acc_wdata,
    output logic [31:0]       rd_data,
    input  logic [PINS-1:0]   irq_req,
    input  logic [PINS-1:0]   rp_set,
    output logic [8*PINS-1:0] ent_vector,
    output logic [3*PINS-1:0] ent_dlv,
    output logic [PINS-1:0]   ent_dstmode,
    output logic [PINS-1:0]   ent_pol,
    output logic [PINS-1:0]   ent_rpend,
    output logic [PINS-1:0]   ent_trig,
    output logic [PINS-1:0]   ent_mask,
    output logic [8*PINS-1:0] ent_dest,
    output logic              mchg_valid,
    output logic [IDX_W-1:0]  mchg_pin,
    output logic              mchg_mask,
    output logic              reeval_valid,
    output logic [IDX_W-1:0]  reeval_pin
);

    logic [31:0]          sel_q;
    logic [IDX_W-1:0]     sel_idx;
    logic                 tbl_wr;
    logic                 tbl_hi;
    logic [31:0]          tbl_wdata;
    rte_t                 sel_entry;
    logic [PINS-1:0][63:0] ent_q;

    irq_regwin_decode #(.PINS(PINS), .VER_CODE(VER_CODE), .IDX_W(IDX_W)) u_decode (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .acc_size  (acc_size),
        .acc_wdata (acc_wdata),
        .sel_entry (sel_entry),
        .sel_q     (sel_q),
        .sel_idx   (sel_idx),
        .tbl_wr    (tbl_wr),
        .tbl_hi    (tbl_hi),
        .tbl_wdata (tbl_wdata),
        .rd_data   (rd_data)
    );

    irq_regwin_table #(.PINS(PINS), .IDX_W(IDX_W)) u_table (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (tbl_wr),
        .wr_hi     (tbl_hi),
        .wr_idx    (sel_idx),
        .wr_data   (tbl_wdata),
        .rp_set    (rp_set),
        .sel_entry (sel_entry),
        .ent_q     (ent_q)
    );

    irq_regwin_events #(.PINS(PINS), .IDX_W(IDX_W)) u_events (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (tbl_wr),
        .wr_hi        (tbl_hi),
        .wr_idx       (sel_idx),
        .wr_data      (tbl_wdata),
        .cur_entry    (sel_entry),
        .irq_req      (irq_req),
        .mchg_valid   (mchg_valid),
        .mchg_pin     (mchg_pin),
        .mchg_mask    (mchg_mask),
        .reeval_valid (reeval_valid),
        .reeval_pin   (reeval_pin)
    );

    for (genvar g = 0; g < PINS; g++) begin : g_exp
        rte_fields_t f;
        assign f                  = rte_unpack(ent_q[g]);
        assign ent_vector[g*8 +: 8] = f.vector;
        assign ent_dlv[g*3 +: 3]    = f.dlv;
        assign ent_dstmode[g]       = f.dstmode;
        assign ent_pol[g]           = f.pol;
        assign ent_rpend[g]         = f.rpend;
        assign ent_trig[g]          = f.trig;
        assign ent_mask[g]          = f.mask;
        assign ent_dest[g*8 +: 8]   = f.dest;
    end

endmodule

// File: rtl/irq_regwin_chk.sv
module irq_regwin_chk #(
    parameter int PINS  = 24,
    parameter int IDX_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [7:0]        acc_addr,
    input logic [3:0]        acc_size,
    input logic [31:0]       sel_q,
    input logic [8*PINS-1:0] ent_vector,
    input logic [8*PINS-1:0] ent_dest,
    input logic [PINS-1:0]   ent_rpend,
    input logic [PINS-1:0]   ent_trig,
    input logic [PINS-1:0]   ent_mask,
    input logic              mchg_valid,
    input logic [IDX_W-1:0]  mchg_pin,
    input logic              mchg_mask,
    input logic              reeval_valid,
    input logic [IDX_W-1:0]  reeval_pin
);

    logic            sz_good;
    logic            win_wr;
    logic [31:0]     cidx;
    logic            hit;
    logic            oob;
    logic [IDX_W-1:0] hidx;

    always_comb begin
        sz_good = (acc_size == 4'd4) || (acc_size == 4'd8);
        win_wr  = acc_valid && acc_write && sz_good && acc_addr == 8'h10;
        cidx    = (sel_q - 32'h10) >> 1;
        hit     = win_wr && sel_q >= 32'h10 && cidx < 32'(PINS);
        oob     = win_wr && sel_q >= 32'h10 && cidx >= 32'(PINS);
        hidx    = cidx[IDX_W-1:0];
    end

    assert_lowclr_R6: assert property (@(posedge clk) disable iff (rst)
        (hit && !sel_q[0]) |=> !ent_rpend[$past(hidx)]);

    assert_oob_stable_R5: assert property (@(posedge clk) disable iff (rst)
        oob |=> ($stable(ent_mask) && $stable(ent_vector) && $stable(ent_dest) && !mchg_valid));

    assert_mchg_agree_R7: assert property (@(posedge clk) disable iff (rst)
        mchg_valid |-> (32'(mchg_pin) < 32'(PINS) && ent_mask[mchg_pin] == mchg_mask));

    assert_mchg_cause_R7: assert property (@(posedge clk) disable iff (rst)
        mchg_valid |-> $past(hit));

    assert_reeval_level_R8: assert property (@(posedge clk) disable iff (rst)
        reeval_valid |-> (ent_trig[reeval_pin] && $past(hit)));

    assert_reset_state_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&ent_mask && sel_q == 32'h0));

    assert_size_filter_R10: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && !sz_good) |=> ($stable(sel_q) && $stable(ent_mask) && $stable(ent_vector) && !mchg_valid));

endmodule

bind irq_regwin irq_regwin_chk #(.PINS(PINS), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/test_irq_regwin.sv
module test_irq_regwin;

    localparam int PERIOD = 10;
    localparam int NP     = 24;
    localparam int IW     = 5;

    logic            clk = 1'b0;
    logic            rst;
    logic            acc_valid, acc_write;
    logic [7:0]      acc_addr;
    logic [3:0]      acc_size;
    logic [31:0]     acc_wdata;
    logic [31:0]     rd_data;
    logic [NP-1:0]   irq_req, rp_set;
    logic [8*NP-1:0] ent_vector, ent_dest;
    logic [3*NP-1:0] ent_dlv;
    logic [NP-1:0]   ent_dstmode, ent_pol, ent_rpend, ent_trig, ent_mask;
    logic            mchg_valid, mchg_mask, reeval_valid;
    logic [IW-1:0]   mchg_pin, reeval_pin;

    always #(PERIOD/2) clk = ~clk;

    irq_regwin i_irq_regwin (.*);

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    // bench model
    logic [63:0]   m_ent [NP];
    logic [31:0]   m_sel;
    logic [3:0]    m_id;
    logic [NP-1:0] m_req;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < NP; i++) m_ent[i] = 64'h0000_0000_0001_0000;
        m_sel = 0; m_id = 0; m_req = 0;
    endfunction

    function automatic logic [31:0] model_read(logic [7:0] a);
        logic [31:0] ix;
        if (a == 8'h00) return m_sel;
        if (a != 8'h10) return 32'h0;
        if (m_sel == 0 || m_sel == 2) return {4'b0, m_id, 24'b0};
        if (m_sel == 1) return {8'h00, 8'(NP - 1), 8'h00, 8'h11};
        if (m_sel < 32'h10) return 32'h0;
        ix = (m_sel - 32'h10) >> 1;
        if (ix >= NP) return 32'h0;
        return m_sel[0] ? m_ent[ix][63:32] : m_ent[ix][31:0];
    endfunction

    function automatic string read_req(logic [7:0] a);
        if (a != 8'h00 && a != 8'h10) return "R1";
        if (a == 8'h00) return "R1";
        if (m_sel == 1) return "R2";
        if (m_sel == 0 || m_sel == 2) return "R3";
        if (m_sel >= 32'h10 && ((m_sel - 32'h10) >> 1) >= NP) return "R5";
        return "R4";
    endfunction

    task automatic step(input logic v, input logic w, input logic [7:0] a,
                        input logic [3:0] sz, input logic [31:0] d,
                        input logic [NP-1:0] rp, input logic [NP-1:0] irq);
        logic [63:0] nx [NP];
        logic [31:0] n_sel, e_rd, ix;
        logic [3:0]  n_id;
        bit e_rdv, e_mc, e_mm, e_rv;
        int e_pin;
        string rq;
        logic [8*NP-1:0] xv, xd;
        logic [3*NP-1:0] xdl;
        logic [NP-1:0] xdm, xp, xr, xt, xm;
        @(negedge clk);
        acc_valid = v; acc_write = w; acc_addr = a; acc_size = sz;
        acc_wdata = d; rp_set = rp; irq_req = irq;
        e_rdv = v && !w; e_rd = model_read(a); rq = read_req(a);
        e_mc = 0; e_mm = 0; e_rv = 0; e_pin = 0;
        for (int i = 0; i < NP; i++) begin
            nx[i] = m_ent[i];
            if (rp[i]) nx[i][14] = 1'b1;
        end
        n_sel = m_sel; n_id = m_id;
        if (v && w && (sz == 4 || sz == 8)) begin
            if (a == 8'h00) n_sel = d;
            if (a == 8'h10 && m_sel == 0) n_id = d[27:24];
            if (a == 8'h10 && m_sel >= 32'h10) begin
                ix = (m_sel - 32'h10) >> 1;
                if (ix < NP) begin
                    logic [63:0] o, n;
                    o = nx[ix];
                    if (m_sel[0]) n = {d, o[31:0]};
                    else begin n = {o[63:32], d}; n[14] = 1'b0; end
                    nx[ix] = n;
                    e_pin = int'(ix);
                    e_mc = n[16] != o[16];
                    e_mm = n[16];
                    e_rv = n[15] && m_req[ix];
                end
            end
        end
        @(posedge clk);
        #1;
        for (int i = 0; i < NP; i++) m_ent[i] = nx[i];
        m_sel = n_sel; m_id = n_id; m_req = irq;
        if (e_rdv) chk(rd_data === e_rd, rq, "read data", 64'(rd_data), 64'(e_rd));
        chk(mchg_valid === e_mc, "R7", "mask event", 64'(mchg_valid), 64'(e_mc));
        if (e_mc) chk(mchg_pin === IW'(e_pin) && mchg_mask === e_mm, "R7", "mask event pin/value",
                      64'({mchg_pin, mchg_mask}), 64'({IW'(e_pin), e_mm}));
        chk(reeval_valid === e_rv, "R8", "reeval event", 64'(reeval_valid), 64'(e_rv));
        if (e_rv) chk(reeval_pin === IW'(e_pin), "R8", "reeval pin", 64'(reeval_pin), 64'(e_pin));
        for (int i = 0; i < NP; i++) begin
            xv[i*8 +: 8] = m_ent[i][7:0];
            xdl[i*3 +: 3] = m_ent[i][10:8];
            xdm[i] = m_ent[i][11]; xp[i] = m_ent[i][13]; xr[i] = m_ent[i][14];
            xt[i] = m_ent[i][15]; xm[i] = m_ent[i][16];
            xd[i*8 +: 8] = m_ent[i][63:56];
        end
        chk(ent_mask === xm && ent_trig === xt, "R11", "mask/trigger export",
            64'({ent_mask, ent_trig}), 64'({xm, xt}));
        chk(ent_rpend === xr, "R12", "remote-pending export", 64'(ent_rpend), 64'(xr));
        chk(ent_vector === xv && ent_dest === xd && ent_dlv === xdl && ent_dstmode === xdm && ent_pol === xp,
            "R11", "field export", 64'(ent_vector[63:0]), 64'(xv[63:0]));
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(1, 1, a, 4'd4, d, '0, irq_req);
    endtask

    task automatic rd(input logic [7:0] a);
        step(1, 0, a, 4'd4, 32'h0, '0, irq_req);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            nfail++; nchk++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd1357;
        void'($urandom(seed));
        acc_valid = 0; acc_write = 0; acc_addr = 0; acc_size = 0; acc_wdata = 0;
        rp_set = 0; irq_req = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
        #1;
        // R9: reset state
        chk(ent_mask === '1, "R9", "all masked after reset", 64'(ent_mask), 64'({NP{1'b1}}));
        rd(8'h00);
        chk(rd_data === 32'h0, "R9", "select after reset", 64'(rd_data), 64'h0);

        // R1: offsets
        wr(8'h00, 32'h0000_0013); rd(8'h00);
        rd(8'h20);
        wr(8'h30, 32'hFFFF_FFFF); rd(8'h00);
        chk(rd_data === 32'h13, "R1", "stray write ignored", 64'(rd_data), 64'h13);

        // R2: version
        wr(8'h00, 32'h1); rd(8'h10);
        chk(rd_data === 32'h0017_0011, "R2", "version value", 64'(rd_data), 64'h0017_0011);
        wr(8'h10, 32'hFFFF_FFFF); rd(8'h10);

        // R3: ID and arbitration
        wr(8'h00, 32'h0); wr(8'h10, 32'hA5FF_FFFF); rd(8'h10);
        chk(rd_data === 32'h0500_0000, "R3", "id readback", 64'(rd_data), 64'h0500_0000);
        wr(8'h00, 32'h2); wr(8'h10, 32'h0F00_0000); rd(8'h10);
        chk(rd_data === 32'h0500_0000, "R3", "arb write ignored", 64'(rd_data), 64'h0500_0000);

        // R4 / R7: entry 5 low and high halves, unmask
        wr(8'h00, 32'h1A); wr(8'h10, 32'h0000_A2B3); rd(8'h10);
        wr(8'h00, 32'h1B); wr(8'h10, 32'h7F00_0000); rd(8'h10);
        chk(ent_dest[5*8 +: 8] === 8'h7F, "R4", "high half dest", 64'(ent_dest[5*8 +: 8]), 64'h7F);

        // R5: index beyond table
        wr(8'h00, 32'h40); wr(8'h10, 32'h0000_0000); rd(8'h10);
        wr(8'h00, 32'h3F); wr(8'h10, 32'h1234_5678); rd(8'h10);

        // R12 / R6: remote pending vs writes, including collision
        step(0, 0, 8'h00, 4'd4, 0, NP'(1) << 5, '0);
        wr(8'h00, 32'h1A); rd(8'h10);
        wr(8'h00, 32'h1B); wr(8'h10, 32'h7F00_0000);
        chk(ent_rpend[5] === 1'b1, "R6", "high write keeps pending", 64'(ent_rpend[5]), 64'h1);
        wr(8'h00, 32'h1A);
        step(1, 1, 8'h10, 4'd8, 32'h0000_80B3, NP'(1) << 5, '0);
        chk(ent_rpend[5] === 1'b0, "R6", "low write clear beats set", 64'(ent_rpend[5]), 64'h0);

        // R8: level entry with request held
        step(0, 0, 8'h00, 4'd4, 0, '0, NP'(1) << 5);
        step(1, 1, 8'h10, 4'd4, 32'h0001_80B3, '0, NP'(1) << 5);
        chk(mchg_mask === 1'b1, "R7", "remask value", 64'(mchg_mask), 64'h1);

        // R10: bad sizes
        step(1, 1, 8'h00, 4'd2, 32'h55, '0, '0);
        step(1, 1, 8'h10, 4'd1, 32'h0, '0, '0);
        rd(8'h00);
        chk(rd_data === 32'h1A, "R10", "short write ignored", 64'(rd_data), 64'h1A);

        // random phase
        for (int n = 0; n < 3000; n++) begin
            int unsigned op;
            logic [31:0] d;
            logic [3:0]  sz;
            logic [NP-1:0] rp, iq;
            op = $urandom_range(0, 99);
            d  = $urandom();
            sz = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(1, 3)) : (op[0] ? 4'd8 : 4'd4);
            rp = ($urandom_range(0, 7) == 0) ? NP'(1) << $urandom_range(0, NP-1) : '0;
            iq = ($urandom_range(0, 15) == 0) ? NP'($urandom()) : irq_req;
            if (op < 30) begin
                case ($urandom_range(0, 4))
                    0: d = 32'($urandom_range(0, 2));
                    1: d = d;
                    default: d = 32'($urandom_range(16, 69));
                endcase
                step(1, 1, 8'h00, sz, d, rp, iq);
            end else if (op < 62) begin
                step(1, 1, 8'h10, sz, d, rp, iq);
            end else if (op < 90) begin
                step(1, 0, ($urandom_range(0, 5) == 0) ? 8'($urandom()) : (op[1] ? 8'h10 : 8'h00),
                     4'd4, 0, rp, iq);
            end else if (op < 95) begin
                step(1, 1, 8'($urandom()) | 8'h01, 4'd4, d, rp, iq);
            end else begin
                step(0, 0, 8'h00, 4'd4, 0, rp, iq);
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule